// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block turns one load-multiple or store-multiple operation into a series of single memory transfers. It moves a fixed list of callee-saved registers, and optionally the return-address register, between the register file and consecutive memory locations. A caller presents a start address, a five-bit list field, a direction and an element size, and pulses `start`. The sequencer then steps through the list one element at a time. For each element it drives the register-file port and a request/acknowledge memory port.

The low four bits of the list field give how many entries of the register table to move. The table lists registers 16 through 23 and then register 30. A count outside 1..9 moves no table entry. The top bit of the list field adds one more transfer, for register 31, after the table entries. Word loads are sign-extended to the register width. The block pulses `done` once the last transfer has completed.

Top module: `mreg_seq`

## Requirements
- R1: With a count field (`listField[3:0]`) of N in 1..9, the first N table entries are transferred in table order. The table order is 16, 17, 18, 19, 20, 21, 22, 23, 30.
- R2: A count field of 0 or of 10..15 transfers no table entry.
- R3: When `listField[4]` is 1, one extra transfer of register 31 follows all table transfers, at the next address in the sequence.
- R4: The first transfer uses `startAddr`. Each later transfer adds 4 to the address when `isDouble`=0 (word) and 8 when `isDouble`=1 (doubleword).
- R5: On a load, the register is written with `rfWrEn` in the acknowledge cycle. A word load writes `memRData[31:0]` sign-extended to XLEN bits. A doubleword load writes all of `memRData`.
- R6: Only one transfer is outstanding at a time. `memReq`, `memAddr` and `memWe` stay constant from the request until `memAck`.
- R7: When the list selects nothing, `done` is 1 in the cycle after `start` is sampled, and `memReq` never rises.
- R8: `done` is high for exactly one cycle, in the cycle after the final `memAck`.
- R9: A `start` sampled while `busy`=1 has no effect on the running sequence: its addresses, direction, size and register list stay unchanged.
- R10: A store drives `memWe`=1. Its `memWData` is the value read from the register file: the full value for a doubleword, or the low 32 bits with the upper bits zero for a word. A load drives `memWe`=0.
- R11: After reset, `busy`, `done`, `memReq` and `rfWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| startAddr | input | ADDR_W | Address of the first element |
| listField | input | 5 | [3:0] table count, [4] adds register 31 |
| isLoad | input | 1 | 1 = memory to registers, 0 = registers to memory |
| isDouble | input | 1 | 1 = doubleword elements, 0 = word elements |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rfRdIdx | output | 5 | Register-file read index |
| rfRdData | input | XLEN | Register-file read data (combinational) |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrIdx | output | 5 | Register-file write index |
| rfWrData | output | XLEN | Register-file write data |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = write to memory |
| memDword | output | 1 | 1 = eight-byte transfer |
| memAddr | output | ADDR_W | Memory byte address |
| memWData | output | XLEN | Memory write data |
| memAck | input | 1 | Memory completes the current transfer |
| memRData | input | XLEN | Memory read data, valid with memAck |

## Verification
A wrong step counter or a wrong table decode shows up at the ports on the very next acknowledge. The bench would then see the wrong register index or an address off by one stride. A latched count or return-address flag that is wrong changes the number of transfers, so `done` comes early or late relative to the final acknowledge. A corrupted mode latch, for example from a `start` accepted while busy, flips `memWe` or `memDword` in the middle of a sequence. That shows up within one transfer. A sign-extension fault appears only on word loads whose bit 31 is set, so addresses on both sides of that bit are used.

// File: rtl/mreg_pkg.sv
package mreg_pkg;

  localparam int LIST_W     = 5;
  localparam int LIST_CNT_W = 4;
  localparam int REG_IDX_W  = 5;
  localparam int TABLE_LEN  = 9;
  localparam int LOW_RUN    = 8;   // entries 0..7 map to registers 16..23
  localparam int LOW_BASE   = 16;
  localparam int TAIL_REG   = 30;
  localparam int RA_REG     = 31;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = 4;
  localparam int DWORD_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;   // latch operation parameters
    logic advance;   // current transfer completed
  } seqStrb_t;

  function automatic logic [REG_IDX_W-1:0] tableReg(input logic [LIST_CNT_W-1:0] pos);
    if (pos < LIST_CNT_W'(LOW_RUN))
      return REG_IDX_W'(LOW_BASE) + REG_IDX_W'(pos);
    else
      return REG_IDX_W'(TAIL_REG);
  endfunction

endpackage

// File: rtl/mreg_dp.sv
module mreg_dp
  import mreg_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrb_t             strb,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [LIST_W-1:0]    listField,
  input  logic                 isLoad,
  input  logic                 isDouble,
  input  logic [XLEN-1:0]      rfRdData,
  input  logic [XLEN-1:0]      memRData,
  output logic                 startEmpty,
  output logic                 lastXfer,
  output logic                 loadMode,
  output logic                 dwMode,
  output logic [ADDR_W-1:0]    curAddr,
  output logic [REG_IDX_W-1:0] curReg,
  output logic [XLEN-1:0]      memWData,
  output logic [XLEN-1:0]      rfWrData
);

  localparam int CNT_W = $clog2(TABLE_LEN + 2);

  logic [LIST_CNT_W-1:0] rawCnt;
  logic                  rawRa;
  logic                  cntValid;
  logic [CNT_W-1:0]      cntDecoded;
  logic [CNT_W-1:0]      tblCnt;
  logic                  raReq;
  logic [CNT_W-1:0]      stepIdx;
  logic [CNT_W-1:0]      totalXfers;
  logic [ADDR_W-1:0]     strideBytes;

  assign rawCnt     = listField[LIST_CNT_W-1:0];
  assign rawRa      = listField[LIST_W-1];
  assign cntValid   = (rawCnt != '0) && (rawCnt <= LIST_CNT_W'(TABLE_LEN));
  assign cntDecoded = cntValid ? CNT_W'(rawCnt) : '0;
  assign startEmpty = (cntDecoded == '0) && !rawRa;

  assign totalXfers = tblCnt + CNT_W'(raReq);
  assign lastXfer   = (stepIdx + CNT_W'(1)) == totalXfers;
  assign strideBytes = dwMode ? ADDR_W'(DWORD_BYTES) : ADDR_W'(WORD_BYTES);

  always_comb begin
    if (stepIdx < tblCnt)
      curReg = tableReg(LIST_CNT_W'(stepIdx));
    else
      curReg = REG_IDX_W'(RA_REG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      stepIdx  <= '0;
      tblCnt   <= '0;
      raReq    <= 1'b0;
      loadMode <= 1'b0;
      dwMode   <= 1'b0;
    end else if (strb.capture) begin
      curAddr  <= startAddr;
      stepIdx  <= '0;
      tblCnt   <= cntDecoded;
      raReq    <= rawRa;
      loadMode <= isLoad;
      dwMode   <= isDouble;
    end else if (strb.advance) begin
      curAddr  <= curAddr + strideBytes;
      stepIdx  <= stepIdx + CNT_W'(1);
    end
  end

  generate
    if (XLEN > WORD_W) begin : g_wide
      assign memWData = dwMode ? rfRdData
                               : {{(XLEN-WORD_W){1'b0}}, rfRdData[WORD_W-1:0]};
      assign rfWrData = dwMode ? memRData
                               : {{(XLEN-WORD_W){memRData[WORD_W-1]}}, memRData[WORD_W-1:0]};
    end else begin : g_narrow
      assign memWData = rfRdData;
      assign rfWrData = memRData;
    end
  endgenerate

  // the step index never moves past the last selected transfer
  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> (stepIdx < totalXfers));

  // a captured operation never holds more transfers than table plus one
  p_count_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (tblCnt <= CNT_W'(TABLE_LEN)));

endmodule

// File: rtl/mreg_ctrl.sv
module mreg_ctrl
  import mreg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     startEmpty,
  input  logic     lastXfer,
  input  logic     loadMode,
  input  logic     memAck,
  output seqStrb_t strb,
  output logic     memReq,
  output logic     rfWrEn,
  output logic     busy,
  output logic     done
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    strb.capture = 1'b0;
    strb.advance = 1'b0;
    memReq       = 1'b0;
    rfWrEn       = 1'b0;
    done         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.capture = 1'b1;
          stateNext    = startEmpty ? ST_FIN : ST_XFER;
        end
      end
      ST_XFER: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.advance = 1'b1;
          rfWrEn       = loadMode;
          if (lastXfer) stateNext = ST_FIN;
        end
      end
      ST_FIN: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_empty_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && startEmpty) |=> (done && !memReq));

  p_reset_quiet_r11: assert property (@(posedge clk)
    !rstN |=> (!busy && !memReq && !done));

endmodule

// File: rtl/mreg_seq.sv
module mreg_seq
  import mreg_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [LIST_W-1:0]    listField,
  input  logic                 isLoad,
  input  logic                 isDouble,
  output logic                 busy,
  output logic                 done,
  output logic [REG_IDX_W-1:0] rfRdIdx,
  input  logic [XLEN-1:0]      rfRdData,
  output logic                 rfWrEn,
  output logic [REG_IDX_W-1:0] rfWrIdx,
  output logic [XLEN-1:0]      rfWrData,
  output logic                 memReq,
  output logic                 memWe,
  output logic                 memDword,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [XLEN-1:0]      memWData,
  input  logic                 memAck,
  input  logic [XLEN-1:0]      memRData
);

  seqStrb_t              strb;
  logic                  startEmpty;
  logic                  lastXfer;
  logic                  loadMode;
  logic                  dwMode;
  logic [REG_IDX_W-1:0]  curReg;

  mreg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .startEmpty (startEmpty),
    .lastXfer   (lastXfer),
    .loadMode   (loadMode),
    .memAck     (memAck),
    .strb       (strb),
    .memReq     (memReq),
    .rfWrEn     (rfWrEn),
    .busy       (busy),
    .done       (done)
  );

  mreg_dp #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .startAddr  (startAddr),
    .listField  (listField),
    .isLoad     (isLoad),
    .isDouble   (isDouble),
    .rfRdData   (rfRdData),
    .memRData   (memRData),
    .startEmpty (startEmpty),
    .lastXfer   (lastXfer),
    .loadMode   (loadMode),
    .dwMode     (dwMode),
    .curAddr    (memAddr),
    .curReg     (curReg),
    .memWData   (memWData),
    .rfWrData   (rfWrData)
  );

  assign rfRdIdx  = curReg;
  assign rfWrIdx  = curReg;
  assign memWe    = !loadMode;
  assign memDword = dwMode;

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq && memAck)) |->
      (memAddr == $past(memAddr) + (memDword ? ADDR_W'(DWORD_BYTES) : ADDR_W'(WORD_BYTES))));

  p_write_on_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (memReq && memAck && !memWe));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(memDword) && $stable(memWe)));

  generate
    if (XLEN > WORD_W) begin : g_sext_chk
      p_sext_r5: assert property (@(posedge clk) disable iff (!rstN)
        (rfWrEn && !memDword) |->
          (rfWrData == {{(XLEN-WORD_W){memRData[WORD_W-1]}}, memRData[WORD_W-1:0]}));
    end
  endgenerate

endmodule

// File: tb/mreg_seq_test.sv
module mreg_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] startAddr = '0;
  logic [4:0]  listField = '0;
  logic        isLoad = 1'b0;
  logic        isDouble = 1'b0;
  logic        busy, done;
  logic [4:0]  rfRdIdx, rfWrIdx;
  logic [63:0] rfRdData, rfWrData;
  logic        rfWrEn, memReq, memWe, memDword;
  logic [31:0] memAddr;
  logic [63:0] memWData;
  logic        memAck = 1'b0;
  logic [63:0] memRData = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] logAddr [16];
  logic [4:0]  logReg  [16];
  logic        logWe   [16];
  logic        logDw   [16];
  logic [63:0] logWd   [16];
  int          logN = 0;
  int          lastAckCyc = 0;
  logic [4:0]  wrReg [16];
  logic [63:0] wrVal [16];
  int          wrN = 0;
  int          latency = 0;
  int          waitCnt = 0;
  logic        holdErr = 1'b0;
  logic [31:0] heldAddr = '0;
  int          doneCnt = 0;

  mreg_seq #(.XLEN(64), .ADDR_W(32)) uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .listField(listField), .isLoad(isLoad), .isDouble(isDouble),
    .busy(busy), .done(done), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .memReq(memReq), .memWe(memWe), .memDword(memDword), .memAddr(memAddr),
    .memWData(memWData), .memAck(memAck), .memRData(memRData)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] regVal(input logic [4:0] idx);
    return {24'hC0FFEE, 3'b0, idx, 24'h5A5A00, 3'b0, idx};
  endfunction

  function automatic logic [4:0] expTbl(input int k);
    if (k < 8) return 5'(16 + k);
    return 5'd30;
  endfunction

  assign rfRdData = regVal(rfRdIdx);

  always @(posedge clk) begin
    cyc++;
    if (rstN && rfWrEn) begin
      if (wrN < 16) begin
        wrReg[wrN] = rfWrIdx;
        wrVal[wrN] = rfWrData;
      end
      wrN++;
    end
  end

  // memory responder, acknowledge after `latency` waiting cycles
  always @(negedge clk) begin
    if (!rstN) begin
      memAck  = 1'b0;
      waitCnt = 0;
    end else begin
      if (done) doneCnt++;
      if (memAck) begin
        memAck  = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        if (waitCnt == 0) heldAddr = memAddr;
        else if (memAddr != heldAddr) holdErr = 1'b1;
        if (waitCnt >= latency) begin
          memAck   = 1'b1;
          memRData = {~memAddr, memAddr};
          if (logN < 16) begin
            logAddr[logN] = memAddr;
            logReg[logN]  = rfRdIdx;
            logWe[logN]   = memWe;
            logDw[logN]   = memDword;
            logWd[logN]   = memWData;
          end
          logN++;
          lastAckCyc = cyc;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runSeq(input logic [31:0] a, input logic [4:0] lf, input bit ld,
                        input bit dw, input int lat, input bit intrude);
    int nTbl, nExp, startCyc, waited, doneCyc;
    bit seen;
    logic [4:0]  eReg;
    logic [31:0] eAddr;
    logic [63:0] eData;
    nTbl = (lf[3:0] >= 4'd1 && lf[3:0] <= 4'd9) ? int'(lf[3:0]) : 0;
    nExp = nTbl + int'(lf[4]);
    latency = lat; logN = 0; wrN = 0; holdErr = 1'b0; doneCnt = 0;
    @(negedge clk);
    startAddr = a; listField = lf; isLoad = ld; isDouble = dw; start = 1'b1;
    startCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    seen = done;
    doneCyc = cyc;
    while (!seen && waited < 2000) begin
      if (intrude && waited == 1) begin
        start = 1'b1; isLoad = !ld; isDouble = !dw;
        listField = 5'h19; startAddr = a + 32'h1000;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
      seen = done;
      doneCyc = cyc;
    end
    start = 1'b0;
    chk(seen, "R8", "done seen", 64'(seen), 64'd1);
    if (nExp == 0) begin
      chk(doneCyc == startCyc + 1, "R7", "done one cycle after start",
          64'(doneCyc - startCyc), 64'd1);
      chk(logN == 0, "R7", "no memory request", 64'(logN), 64'd0);
    end else begin
      chk(doneCyc == lastAckCyc + 1, "R8", "done after final ack",
          64'(doneCyc - lastAckCyc), 64'd1);
    end
    @(negedge clk);
    @(negedge clk);
    chk(doneCnt == 1, "R8", "done pulse width", 64'(doneCnt), 64'd1);
    chk(!busy, "R8", "idle after done", 64'(busy), 64'd0);
    chk(logN == nExp, (nTbl == 0) ? "R2" : "R1", "transfer count", 64'(logN), 64'(nExp));
    chk(!holdErr, "R6", "request held stable", 64'(holdErr), 64'd0);
    if (ld) chk(wrN == nExp, "R5", "register write count", 64'(wrN), 64'(nExp));
    for (int k = 0; k < nExp && k < logN && k < 16; k++) begin
      eReg  = (k < nTbl) ? expTbl(k) : 5'd31;
      eAddr = a + 32'(k * (dw ? 8 : 4));
      chk(logAddr[k] == eAddr, "R4", "address", 64'(logAddr[k]), 64'(eAddr));
      chk(logWe[k] == !ld, "R10", "direction", 64'(logWe[k]), 64'(!ld));
      chk(logDw[k] == dw, "R9", "size held", 64'(logDw[k]), 64'(dw));
      if (k < nTbl)
        chk(logReg[k] == eReg, "R1", "table register", 64'(logReg[k]), 64'(eReg));
      else
        chk(logReg[k] == eReg, "R3", "return register last", 64'(logReg[k]), 64'(eReg));
      if (!ld) begin
        eData = dw ? regVal(eReg) : {32'h0, regVal(eReg)[31:0]};
        chk(logWd[k] == eData, "R10", "store data", logWd[k], eData);
      end else if (k < wrN) begin
        eData = dw ? {~eAddr, eAddr} : {{32{eAddr[31]}}, eAddr};
        chk(wrReg[k] == eReg, "R5", "write index", 64'(wrReg[k]), 64'(eReg));
        chk(wrVal[k] == eData, "R5", "write data", wrVal[k], eData);
      end
    end
  endtask

  task automatic testReset();
    chk(!busy && !done, "R11", "busy/done after reset", {62'd0, busy, done}, 64'd0);
    chk(!memReq && !rfWrEn, "R11", "req/wr after reset", {62'd0, memReq, rfWrEn}, 64'd0);
  endtask

  task automatic testStoreWords();   runSeq(32'h0000_0200, 5'h03, 1'b0, 1'b0, 0, 1'b0); endtask
  task automatic testLoadFullList(); runSeq(32'h8000_0100, 5'h19, 1'b1, 1'b0, 2, 1'b0); endtask
  task automatic testLoadDwords();   runSeq(32'h0000_4000, 5'h12, 1'b1, 1'b1, 1, 1'b0); endtask
  task automatic testOnlyRa();       runSeq(32'h0000_0300, 5'h10, 1'b0, 1'b1, 0, 1'b0); endtask
  task automatic testEmptyZero();    runSeq(32'h0000_0400, 5'h00, 1'b1, 1'b0, 0, 1'b0); endtask
  task automatic testEmptyHigh();    runSeq(32'h0000_0500, 5'h0C, 1'b0, 1'b0, 0, 1'b0); endtask
  task automatic testInvalidWithRa(); runSeq(32'h8000_0600, 5'h1D, 1'b1, 1'b0, 1, 1'b0); endtask
  task automatic testBusyIgnore();   runSeq(32'h0000_0700, 5'h02, 1'b0, 1'b0, 3, 1'b1); endtask
  task automatic testStoreDwordsNine(); runSeq(32'h0001_0000, 5'h09, 1'b0, 1'b1, 0, 1'b0); endtask
  task automatic testLoadPositive(); runSeq(32'h0000_0800, 5'h01, 1'b1, 1'b0, 0, 1'b0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStoreWords();
    testLoadFullList();
    testLoadDwords();
    testOnlyRa();
    testEmptyZero();
    testEmptyHigh();
    testInvalidWithRa();
    testBusyIgnore();
    testStoreDwordsNine();
    testLoadPositive();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule